// File: doc/BRIEF.md
# Five-Phase Accumulator Processor

This block is a small 8-bit accumulator machine. Each instruction byte carries a 3-bit operation code in its upper three bits and a 5-bit direct address in its lower five bits. Program bytes come from a 32-entry read-only store and operands from a 32-entry data RAM. The two stores have separate address spaces, and both take their contents from parameters. The RAM reloads its image whenever reset is held.

Every instruction takes the same five clock cycles. A one-hot phase ring steps through fetch, operand read, execute, memory write and accumulator update. The registers inside are a program counter, an instruction register, the accumulator, an ALU result register, an operand register and a zero flag. Outside the block, the accumulator, the program counter, a halted indication and the RAM write port can be observed. That is enough to follow a program run from a testbench or from a larger system model.

Top module: `cpu5_core`

## Requirements
- R1: While synchronous active-low reset is held, `acc_o` and `pc_o` read 0, `ram_we_o` is 0 and `halted_o` is 1, because the cleared instruction register decodes as HALT. The first fetch happens on the second rising edge after reset is released.
- R2: The phase ring visits 00001, 00010, 00100, 01000, 10000 and then returns to 00001. A cleared or illegal ring value goes to 00001 on the next edge, so each instruction occupies exactly five cycles.
- R3: Bits 7:5 of an instruction hold the operation code and bits 4:0 hold the address. The codes are 000 HALT, 001 SKIP, 010 ADD, 011 AND, 100 XOR, 101 LOAD, 110 STORE and 111 JUMP.
- R4: ADD puts the accumulator plus RAM[address] into the accumulator, wrapping modulo 256. AND and XOR put the bitwise AND or XOR of the same two values into the accumulator.
- R5: LOAD copies RAM[address] into the accumulator.
- R6: STORE raises `ram_we_o` for exactly one cycle, during the memory-write phase. In that cycle `ram_waddr_o` is the address field and `ram_wdata_o` is the accumulator value. No other instruction writes RAM.
- R7: JUMP loads the address field into the program counter, so the next fetch comes from that address.
- R8: SKIP with the zero flag set steps the program counter twice and so passes over the next instruction. With the flag clear it steps once.
- R9: Only ADD, AND and XOR write the zero flag. Each sets it to 1 exactly when its 8-bit result is zero. LOAD, STORE, SKIP, JUMP and HALT leave it unchanged.
- R10: HALT leaves the program counter where it is, so the same HALT is fetched again on every pass. `halted_o` stays high and the accumulator does not change.
- R11: A Fibonacci loop that writes each new term to RAM produces 01, 02, 03, 05, 08, 0D, 15, 22, 37, 59, 90 in that order, then halts once an XOR against the limit 0x90 gives zero.
- R12: The accumulator changes only in the update phase, and only for ADD, AND, XOR and LOAD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_o | output | 8 | Current accumulator value |
| pc_o | output | 5 | Current program counter |
| halted_o | output | 1 | High while the instruction register holds HALT |
| ram_we_o | output | 1 | RAM write strobe, high for one cycle per STORE |
| ram_waddr_o | output | 5 | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |

## Verification
Two paths can move the program counter in the same instruction. The execute-phase increment and the memory-phase second increment of a taken SKIP both touch it. For a JUMP, the increment competes with the load of the address field one phase later. A second program sets the zero flag with AND and then runs a LOAD of a non-zero byte before a SKIP. The skip must still be taken: the only visible result is the store that follows the skipped STORE. The program then runs a SKIP with the flag clear, and the next store must not be skipped. Each store on the write port is judged against a queue filled by an instruction-level model of the program, so a wrong counter step shows up as a missing, extra or misplaced store.

// File: rtl/cpu5_pkg.sv
// Shared definitions for the five-phase accumulator processor.
// Assumes an opcode field that is always three bits wide.
package cpu5_pkg;

    localparam int OPW    = 3;
    localparam int NPHASE = 5;

    // Bit positions inside the one-hot phase vector; their order is the sequence.
    localparam int PH_FETCH  = 0;
    localparam int PH_READ   = 1;
    localparam int PH_EXEC   = 2;
    localparam int PH_MEM    = 3;
    localparam int PH_UPDATE = 4;

    typedef enum logic [OPW-1:0] {
        OP_HALT  = 3'b000,
        OP_SKIP  = 3'b001,
        OP_ADD   = 3'b010,
        OP_AND   = 3'b011,
        OP_XOR   = 3'b100,
        OP_LOAD  = 3'b101,
        OP_STORE = 3'b110,
        OP_JUMP  = 3'b111
    } op_e;

    typedef struct packed {
        logic ir_ld;
        logic opnd_ld;
        logic pc_step;
        logic pc_jump;
        logic res_ld;
        logic zf_ld;
        logic ram_we;
        logic acc_ld;
    } ctrl_t;

endpackage

// File: rtl/cpu5_phase.sv
// One-hot phase ring: every instruction spends one cycle in each phase.
// Assumes synchronous active-low reset; a cleared or illegal value restarts at phase 0.
module cpu5_phase #(
    parameter int N = cpu5_pkg::NPHASE
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] phase_o
);
    localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] ring_q;

    // Rotate the single hot bit, or restart when the value is not one-hot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_q <= '0;
        else if ($onehot(ring_q))
            ring_q <= {ring_q[N-2:0], ring_q[N-1]};
        else
            ring_q <= FIRST;
    end

    assign phase_o = ring_q;

    // R2
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring_q));
    // R2
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_q == '0) |=> (ring_q == FIRST));
    // R2
    phase_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_q != '0) |=> (ring_q == {$past(ring_q[N-2:0]), $past(ring_q[N-1])}));

endmodule

// File: rtl/cpu5_ctrl.sv
// Decoder that turns the current phase and opcode into register enables.
// Assumes a one-hot phase vector; produces no enables while the phase is cleared.
module cpu5_ctrl
    import cpu5_pkg::*;
(
    input  logic [NPHASE-1:0] phase_i,
    input  op_e               op_i,
    input  logic              zero_i,
    output ctrl_t             ctl_o
);
    logic is_logic;
    logic reads_mem;

    // Group the opcodes that share enables.
    always_comb begin
        is_logic  = (op_i == OP_ADD) || (op_i == OP_AND) || (op_i == OP_XOR);
        reads_mem = is_logic || (op_i == OP_LOAD);
    end

    // Per-phase enable table.
    always_comb begin
        ctl_o         = '0;
        ctl_o.ir_ld   = phase_i[PH_FETCH];
        ctl_o.opnd_ld = phase_i[PH_READ] && reads_mem;
        ctl_o.pc_step = (phase_i[PH_EXEC] && (op_i != OP_HALT))
                     || (phase_i[PH_MEM] && (op_i == OP_SKIP) && zero_i);
        ctl_o.pc_jump = phase_i[PH_MEM] && (op_i == OP_JUMP);
        ctl_o.res_ld  = phase_i[PH_EXEC] && (reads_mem || (op_i == OP_STORE));
        ctl_o.zf_ld   = phase_i[PH_EXEC] && is_logic;
        ctl_o.ram_we  = phase_i[PH_MEM] && (op_i == OP_STORE);
        ctl_o.acc_ld  = phase_i[PH_UPDATE] && reads_mem;
    end

endmodule

// File: rtl/cpu5_alu.sv
// Accumulator ALU: add, and, xor, operand pass and accumulator pass.
// Assumes the addition wraps at the data width with no carry kept.
module cpu5_alu
    import cpu5_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] res_o,
    output logic         zero_o
);
    // Choose the result by opcode; every other code passes the accumulator.
    always_comb begin
        unique case (op_i)
            OP_ADD:  res_o = acc_i + opnd_i;
            OP_AND:  res_o = acc_i & opnd_i;
            OP_XOR:  res_o = acc_i ^ opnd_i;
            OP_LOAD: res_o = opnd_i;
            default: res_o = acc_i;
        endcase
        zero_o = (res_o == '0);
    end

endmodule

// File: rtl/cpu5_ram.sv
// Data RAM with combinational read and one synchronous write port.
// Assumes the image is reloaded from INIT while reset is held low.
module cpu5_ram #(
    parameter int W  = 8,
    parameter int AW = 5,
    parameter logic [(2**AW)*W-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o
);
    localparam int DEPTH = 2**AW;

    logic [W-1:0] cells [DEPTH];

    // Reload the image on reset, else perform the addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= INIT[i*W +: W];
        end else if (we_i) begin
            cells[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[addr_i];

endmodule

// File: rtl/cpu5_core.sv
// Five-phase accumulator processor: read-only program store, data RAM,
// and the PC, IR, ACC, result, operand and zero-flag registers.
// Assumes an instruction word of 3 opcode bits plus ADDR_W address bits,
// a synchronous active-low reset and separate program and data spaces.
module cpu5_core
    import cpu5_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter logic [(2**ADDR_W)*(OPW+ADDR_W)-1:0] ROM_IMAGE = '0,
    parameter logic [(2**ADDR_W)*DATA_W-1:0]       RAM_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              halted_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_waddr_o,
    output logic [DATA_W-1:0] ram_wdata_o
);
    localparam int IW = OPW + ADDR_W;

    logic [NPHASE-1:0] phase;
    logic [ADDR_W-1:0] pc_q;
    logic [IW-1:0]     ir_q;
    logic [IW-1:0]     rom_word;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] ram_rdata;
    logic              zero_q;
    logic              alu_zero;
    logic [ADDR_W-1:0] addr_f;
    op_e               op;
    ctrl_t             ctl;

    assign op       = op_e'(ir_q[IW-1 -: OPW]);
    assign addr_f   = ir_q[ADDR_W-1:0];
    assign rom_word = ROM_IMAGE[int'(pc_q)*IW +: IW];

    cpu5_phase #(.N(NPHASE)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    cpu5_ctrl u_ctrl (
        .phase_i (phase),
        .op_i    (op),
        .zero_i  (zero_q),
        .ctl_o   (ctl)
    );

    cpu5_alu #(.W(DATA_W)) u_alu (
        .op_i   (op),
        .acc_i  (acc_q),
        .opnd_i (opnd_q),
        .res_o  (alu_res),
        .zero_o (alu_zero)
    );

    cpu5_ram #(.W(DATA_W), .AW(ADDR_W), .INIT(RAM_IMAGE)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl.ram_we),
        .addr_i  (addr_f),
        .wdata_i (res_q),
        .rdata_o (ram_rdata)
    );

    // Program counter: a jump wins, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)           pc_q <= '0;
        else if (ctl.pc_jump) pc_q <= addr_f;
        else if (ctl.pc_step) pc_q <= pc_q + 1'b1;
    end

    // Instruction register loads the addressed program byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir_q <= '0;
        else if (ctl.ir_ld) ir_q <= rom_word;
    end

    // Operand register captures the RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n)           opnd_q <= '0;
        else if (ctl.opnd_ld) opnd_q <= ram_rdata;
    end

    // Result register and zero flag take the ALU outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            zero_q <= 1'b0;
        end else begin
            if (ctl.res_ld) res_q  <= alu_res;
            if (ctl.zf_ld)  zero_q <= alu_zero;
        end
    end

    // Accumulator takes the result in the update phase.
    always_ff @(posedge clk) begin
        if (!rst_n)          acc_q <= '0;
        else if (ctl.acc_ld) acc_q <= res_q;
    end

    assign acc_o       = acc_q;
    assign pc_o        = pc_q;
    assign halted_o    = (op == OP_HALT);
    assign ram_we_o    = ctl.ram_we;
    assign ram_waddr_o = addr_f;
    assign ram_wdata_o = res_q;

    // R6
    store_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (phase[PH_MEM] && (op == OP_STORE)));
    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[PH_MEM] && (op == OP_JUMP)) |=> (pc_q == $past(addr_f)));
    // R9
    zero_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[PH_EXEC] && ((op == OP_ADD) || (op == OP_AND) || (op == OP_XOR)))
        |=> (zero_q == (res_q == '0)));
    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[PH_EXEC] && (op == OP_HALT)) |=> $stable(pc_q));
    // R12
    acc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase[PH_UPDATE] |=> $stable(acc_q));

endmodule

// File: tb/cpu5_core_bench.sv
// Scoreboard bench: an instruction-level model queues the expected stores,
// monitors compare each RAM write strobe of two processor instances.
module cpu5_core_bench;

    localparam int WATCH = 20000;

    // R3: opcode in bits 7:5, address in bits 4:0.
    function automatic logic [255:0] rom_fib();
        logic [255:0] m;
        m = '0;
        m[0*8 +: 8]  = 8'hE3;  // JUMP 3
        m[3*8 +: 8]  = 8'hBD;  // LOAD 29
        m[4*8 +: 8]  = 8'hDF;  // STORE 31
        m[5*8 +: 8]  = 8'h5C;  // ADD 28
        m[6*8 +: 8]  = 8'hDD;  // STORE 29
        m[7*8 +: 8]  = 8'hBF;  // LOAD 31
        m[8*8 +: 8]  = 8'hDC;  // STORE 28
        m[9*8 +: 8]  = 8'hBD;  // LOAD 29
        m[10*8 +: 8] = 8'h9E;  // XOR 30
        m[11*8 +: 8] = 8'h20;  // SKIP
        m[12*8 +: 8] = 8'hE3;  // JUMP 3
        m[13*8 +: 8] = 8'h00;  // HALT
        return m;
    endfunction

    function automatic logic [255:0] ram_fib();
        logic [255:0] m;
        m = '0;
        m[28*8 +: 8] = 8'h00;
        m[29*8 +: 8] = 8'h01;
        m[30*8 +: 8] = 8'h90;
        m[31*8 +: 8] = 8'h00;
        return m;
    endfunction

    function automatic logic [255:0] rom_mix();
        logic [255:0] m;
        m = '0;
        m[0*8 +: 8]  = 8'hB4;  // LOAD 20
        m[1*8 +: 8]  = 8'h75;  // AND 21
        m[2*8 +: 8]  = 8'hD8;  // STORE 24
        m[3*8 +: 8]  = 8'h95;  // XOR 21
        m[4*8 +: 8]  = 8'hD9;  // STORE 25
        m[5*8 +: 8]  = 8'h57;  // ADD 23
        m[6*8 +: 8]  = 8'hDA;  // STORE 26
        m[7*8 +: 8]  = 8'h76;  // AND 22 -> zero
        m[8*8 +: 8]  = 8'hB4;  // LOAD 20, flag kept
        m[9*8 +: 8]  = 8'h20;  // SKIP taken
        m[10*8 +: 8] = 8'hDB;  // STORE 27 skipped
        m[11*8 +: 8] = 8'hDC;  // STORE 28
        m[12*8 +: 8] = 8'h55;  // ADD 21
        m[13*8 +: 8] = 8'h20;  // SKIP not taken
        m[14*8 +: 8] = 8'hDD;  // STORE 29
        m[15*8 +: 8] = 8'h00;  // HALT
        return m;
    endfunction

    function automatic logic [255:0] ram_mix();
        logic [255:0] m;
        m = '0;
        m[20*8 +: 8] = 8'hF0;
        m[21*8 +: 8] = 8'h3C;
        m[22*8 +: 8] = 8'h00;
        m[23*8 +: 8] = 8'hFF;
        return m;
    endfunction

    localparam logic [255:0] ROM_A = rom_fib();
    localparam logic [255:0] RAM_A = ram_fib();
    localparam logic [255:0] ROM_B = rom_mix();
    localparam logic [255:0] RAM_B = ram_mix();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0] acc_a, wd_a, acc_b, wd_b;
    logic [4:0] pc_a, wa_a, pc_b, wa_b;
    logic       halt_a, we_a, halt_b, we_b;

    cpu5_core #(.ROM_IMAGE(ROM_A), .RAM_IMAGE(RAM_A)) u_cpu5_core (
        .clk(clk), .rst_n(rst_n), .acc_o(acc_a), .pc_o(pc_a), .halted_o(halt_a),
        .ram_we_o(we_a), .ram_waddr_o(wa_a), .ram_wdata_o(wd_a));

    cpu5_core #(.ROM_IMAGE(ROM_B), .RAM_IMAGE(RAM_B)) u_cpu5_core_b (
        .clk(clk), .rst_n(rst_n), .acc_o(acc_b), .pc_o(pc_b), .halted_o(halt_b),
        .ram_we_o(we_b), .ram_waddr_o(wa_b), .ram_wdata_o(wd_b));

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [12:0] qa[$];
    logic [12:0] qb[$];
    logic [12:0] log_b[$];
    int n_a = 0, t0_a = 0, t1_a = 0, n_terms = 0;
    logic prev_we_a = 1'b0, prev_we_b = 1'b0;
    logic [7:0] terms [11] = '{8'h01, 8'h02, 8'h03, 8'h05, 8'h08, 8'h0D,
                               8'h15, 8'h22, 8'h37, 8'h59, 8'h90};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: instruction-level model that queues every expected store.
    task automatic model(input logic [255:0] rom, input logic [255:0] ram_img,
                         input bit which, output logic [7:0] acc_f, output logic [4:0] pc_f);
        logic [7:0] mem [32];
        logic [7:0] acc, ins, v;
        logic [4:0] pc, a;
        logic       z;
        bit         stop;
        for (int i = 0; i < 32; i++) mem[i] = ram_img[i*8 +: 8];
        acc = 0; pc = 0; z = 0; stop = 0;
        for (int s = 0; s < 4000 && !stop; s++) begin
            ins = rom[int'(pc)*8 +: 8];
            a = ins[4:0];
            v = mem[a];
            case (ins[7:5])
                3'b000: stop = 1;
                3'b001: pc = pc + (z ? 5'd2 : 5'd1);
                3'b010: begin acc = acc + v; z = (acc == 0); pc++; end
                3'b011: begin acc = acc & v; z = (acc == 0); pc++; end
                3'b100: begin acc = acc ^ v; z = (acc == 0); pc++; end
                3'b101: begin acc = v; pc++; end
                3'b110: begin
                    mem[a] = acc;
                    if (which) qb.push_back({a, acc}); else qa.push_back({a, acc});
                    pc++;
                end
                default: pc = a;
            endcase
        end
        acc_f = acc;
        pc_f = pc;
    endtask

    always @(negedge clk) cyc++;

    // Monitor A: scoreboard compare, pulse width, spacing and Fibonacci order.
    always @(negedge clk) begin
        if (rst_n && we_a) begin
            logic [12:0] e;
            chk(!prev_we_a, "R6", "A strobe longer than one cycle", 1, 0);
            if (qa.size() == 0) begin
                chk(0, "R6", "A unexpected store addr", int'(wa_a), 0);
            end else begin
                e = qa.pop_front();
                chk({wa_a, wd_a} == e, "R6", "A store addr/data", int'({wa_a, wd_a}), int'(e));
            end
            if (n_a == 0) t0_a = cyc;
            if (n_a == 1) t1_a = cyc;
            n_a++;
            if (wa_a == 5'd29) begin
                if (n_terms < 11)
                    chk(wd_a == terms[n_terms], "R11", "Fibonacci term", int'(wd_a), int'(terms[n_terms]));
                else
                    chk(0, "R11", "term after limit", int'(wd_a), 0);
                n_terms++;
            end
        end
        prev_we_a <= rst_n && we_a;
    end

    // Monitor B: scoreboard compare and a log for targeted checks.
    always @(negedge clk) begin
        if (rst_n && we_b) begin
            logic [12:0] e;
            chk(!prev_we_b, "R6", "B strobe longer than one cycle", 1, 0);
            log_b.push_back({wa_b, wd_b});
            if (qb.size() == 0) begin
                chk(0, "R8", "B unexpected store addr", int'(wa_b), 0);
            end else begin
                e = qb.pop_front();
                chk({wa_b, wd_b} == e, "R6", "B store addr/data", int'({wa_b, wd_b}), int'(e));
            end
        end
        prev_we_b <= rst_n && we_b;
    end

    initial begin
        logic [7:0] macc_a, macc_b;
        logic [4:0] mpc_a, mpc_b, hold_pc;
        logic [7:0] hold_acc;
        model(ROM_A, RAM_A, 1'b0, macc_a, mpc_a);
        model(ROM_B, RAM_B, 1'b1, macc_b, mpc_b);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(acc_a == 0 && acc_b == 0, "R1", "reset acc", int'(acc_a), 0);
        chk(pc_a == 0 && pc_b == 0, "R1", "reset pc", int'(pc_a), 0);
        chk(halt_a && halt_b, "R1", "reset halted", int'(halt_a), 1);
        chk(!we_a && !we_b, "R1", "reset strobe", int'(we_a), 0);
        rst_n = 1'b1;
        while (!(cyc > 60 && halt_a && halt_b) && cyc < WATCH) @(negedge clk);
        if (cyc >= WATCH) chk(0, "R10", "watchdog expired", cyc, WATCH);
        repeat (10) @(negedge clk);
        // R2: STORE 31 and STORE 29 are two instructions apart
        chk(t1_a - t0_a == 10, "R2", "store spacing", t1_a - t0_a, 10);
        // R11 / R7: the whole sequence appeared, loop closed by JUMP
        chk(n_terms == 11, "R11", "term count", n_terms, 11);
        chk(qa.size() == 0, "R6", "A stores missing", qa.size(), 0);
        chk(qb.size() == 0, "R8", "B stores missing", qb.size(), 0);
        // R4: AND, XOR and wrapping ADD results
        if (log_b.size() >= 5) begin
            chk(log_b[0] == {5'd24, 8'h30}, "R4", "AND result", int'(log_b[0]), int'({5'd24, 8'h30}));
            chk(log_b[1] == {5'd25, 8'h0C}, "R4", "XOR result", int'(log_b[1]), int'({5'd25, 8'h0C}));
            chk(log_b[2] == {5'd26, 8'h0B}, "R4", "ADD wrap", int'(log_b[2]), int'({5'd26, 8'h0B}));
            // R8 R9 R5: LOAD kept the flag, the skip was taken, LOAD value stored
            chk(log_b[3] == {5'd28, 8'hF0}, "R8", "taken skip", int'(log_b[3]), int'({5'd28, 8'hF0}));
            chk(log_b[4] == {5'd29, 8'h2C}, "R9", "untaken skip", int'(log_b[4]), int'({5'd29, 8'h2C}));
        end
        chk(log_b.size() == 5, "R8", "B store count", log_b.size(), 5);
        // R10: halt state and hold
        chk(pc_a == 5'd13 && pc_a == mpc_a, "R10", "A halt pc", int'(pc_a), 13);
        chk(acc_a == 8'h00 && acc_a == macc_a, "R12", "A final acc", int'(acc_a), 0);
        chk(pc_b == 5'd15 && pc_b == mpc_b, "R10", "B halt pc", int'(pc_b), 15);
        chk(acc_b == 8'h2C && acc_b == macc_b, "R5", "B final acc", int'(acc_b), 8'h2C);
        hold_pc = pc_b;
        hold_acc = acc_b;
        repeat (23) @(negedge clk);
        chk(pc_b == hold_pc && halt_b, "R10", "pc held under halt", int'(pc_b), int'(hold_pc));
        chk(acc_b == hold_acc, "R10", "acc held under halt", int'(acc_b), int'(hold_acc));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule